// File: doc/BRIEF.md
# Configurable Pin Interrupt Detector

This block watches a bank of already filtered input pins and raises a single combined interrupt request when a pin shows the activity it is set up to detect. Out of reset every pin reports any change of value, rising or falling. Software may switch individual pins into an extended detection mode. In that mode a pin is an edge detector or a level detector, and it fires on one polarity only.

All configuration sits in set/clear register pairs on a simple single-cycle register bus. A write to a "set" offset turns on the written one-bits, and a write to a "clear" offset turns them off. Bits written as zero are not touched. Detected events collect in a per-pin status register, and a read of that register returns its contents and empties it. The interrupt line is high while any collected event belongs to a pin that is enabled in the interrupt mask.

Each pin's detection kind is decoded into one of five named triggers:

| Trigger | Fires on |
|---|---|
| `TRIG_ANY_EDGE` | any change |
| `TRIG_RISE` | a 0→1 change |
| `TRIG_FALL` | a 1→0 change |
| `TRIG_HIGH` | the pin being 1 |
| `TRIG_LOW` | the pin being 0 |

Each bus cycle is classified as `BUS_IDLE`, `BUS_WRITE` or `BUS_READ`.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset the mask, extended-mode, edge/level, polarity and status registers all read 0 and `irq` is low. A read of any offset not listed below returns 0.
- R2: A write to 0x40 sets the written one-bits of the interrupt mask, and a write to 0x44 clears them. Zero bits leave the mask unchanged. The mask reads back at 0x48.
- R3: A write to 0x B0 sets per-pin extended-mode enable bits, and a write to 0xB4 clears them. They read back at 0xB8.
- R4: A write to 0xC0 selects edge detection for the written pins, and a write to 0xC4 selects level detection. The choice reads back at 0xC8, where 1 means level.
- R5: A write to 0xD0 selects falling edge or low level for the written pins, and a write to 0xD4 selects rising edge or high level. The choice reads back at 0xD8, where 1 means rising/high.
- R6: For a pin whose extended-mode bit is 0, both a rising and a falling change set its status bit, whatever its edge/level and polarity bits hold.
- R7: For a pin in extended mode with edge selected, only the change in the selected direction sets its status bit.
- R8: For a pin in extended mode with level selected, the status bit is set on every clock while the pin equals the selected level. This includes the clock of a clearing read, so the bit reads 1 again straight after.
- R9: A read of offset 0x4C returns the status bits and clears all of them at the same clock edge, except for bits set by events detected on that edge.
- R10: `irq` is high exactly when some status bit is 1 and that pin's mask bit is 1. Status bits latch even for masked pins.
- R11: An edge is found by comparing `pin_in` with its value registered on the previous clock. The status bit shows on the clock edge that first samples the new value, and a read reports it in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPINS | Filtered pin levels |
| bus_en | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, combinational in the access cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the boundaries between the trigger kinds.

- A pin that leaves extended mode must report both edges again. A design that kept its old direction setting would miss one of them.
- A level-low pin must re-latch in the very cycle it is read. A design that let the clearing read win would show an empty status on the following read.
- A masked pin must still collect events while leaving `irq` low. A design that gated status with the mask would lose events that software unmasks later.
- Set/clear writes with sparse data must touch only the written bits. A plain write would wipe neighbouring pins.

Random traffic against a reference model covers mixed configurations.

// File: rtl/pind_pkg.sv
package pind_pkg;

    localparam int PIND_ADDR_W = 8;

    localparam logic [7:0] OFS_MASK_SET = 8'h40;
    localparam logic [7:0] OFS_MASK_CLR = 8'h44;
    localparam logic [7:0] OFS_MASK_RD  = 8'h48;
    localparam logic [7:0] OFS_STAT_RD  = 8'h4C;
    localparam logic [7:0] OFS_EXT_SET  = 8'hB0;
    localparam logic [7:0] OFS_EXT_CLR  = 8'hB4;
    localparam logic [7:0] OFS_EXT_RD   = 8'hB8;
    localparam logic [7:0] OFS_LVL_CLR  = 8'hC0;
    localparam logic [7:0] OFS_LVL_SET  = 8'hC4;
    localparam logic [7:0] OFS_LVL_RD   = 8'hC8;
    localparam logic [7:0] OFS_POL_CLR  = 8'hD0;
    localparam logic [7:0] OFS_POL_SET  = 8'hD4;
    localparam logic [7:0] OFS_POL_RD   = 8'hD8;

    typedef enum logic [2:0] {
        TRIG_ANY_EDGE,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_HIGH,
        TRIG_LOW
    } trig_kind_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WRITE,
        BUS_READ
    } bus_op_t;

endpackage

// File: rtl/pind_setclr.sv
module pind_setclr #(
    parameter int         W       = 32,
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] SET_OFS = 8'h00,
    parameter logic [7:0] CLR_OFS = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      q
);

    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            if (addr == SET_A) begin
                q <= q | wdata;
            end else if (addr == CLR_A) begin
                q <= q & ~wdata;
            end
        end
    end

endmodule

// File: rtl/pind_detect.sv
module pind_detect
    import pind_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] ext_en,
    input  logic [NPINS-1:0] lvl_sel,
    input  logic [NPINS-1:0] pol_sel,
    output logic [NPINS-1:0] prev_o,
    output logic [NPINS-1:0] event_o
);

    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_in;
        end
    end

    assign prev_o = prev_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        trig_kind_t kind;
        logic       hit;

        always_comb begin
            if (!ext_en[g]) begin
                kind = TRIG_ANY_EDGE;
            end else if (lvl_sel[g]) begin
                kind = pol_sel[g] ? TRIG_HIGH : TRIG_LOW;
            end else begin
                kind = pol_sel[g] ? TRIG_RISE : TRIG_FALL;
            end
        end

        always_comb begin
            unique case (kind)
                TRIG_ANY_EDGE: hit = pin_in[g] ^ prev_q[g];
                TRIG_RISE:     hit = pin_in[g] & ~prev_q[g];
                TRIG_FALL:     hit = ~pin_in[g] & prev_q[g];
                TRIG_HIGH:     hit = pin_in[g];
                TRIG_LOW:      hit = ~pin_in[g];
                default:       hit = 1'b0;
            endcase
        end

        assign event_o[g] = hit;
    end

endmodule

// File: rtl/pind_status.sv
module pind_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] event_i,
    input  logic             clr_i,
    input  logic [NPINS-1:0] mask_i,
    output logic [NPINS-1:0] status_o,
    output logic             irq_o
);

    logic [NPINS-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (clr_i ? '0 : status_q) | event_i;
        end
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q & mask_i);

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
    import pind_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = PIND_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq
);

    bus_op_t          op;
    logic             wr_en;
    logic             rd_clr;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] ext_q;
    logic [NPINS-1:0] lvl_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] events;
    logic [NPINS-1:0] status_q;

    always_comb begin
        if (!bus_en) begin
            op = BUS_IDLE;
        end else if (bus_wr) begin
            op = BUS_WRITE;
        end else begin
            op = BUS_READ;
        end
    end

    assign wr_en  = (op == BUS_WRITE);
    assign rd_clr = (op == BUS_READ) && (bus_addr == ADDR_W'(OFS_STAT_RD));

    pind_setclr #(.W(NPINS), .ADDR_W(ADDR_W), .SET_OFS(OFS_MASK_SET), .CLR_OFS(OFS_MASK_CLR))
        u_mask (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata), .q(mask_q));

    pind_setclr #(.W(NPINS), .ADDR_W(ADDR_W), .SET_OFS(OFS_EXT_SET), .CLR_OFS(OFS_EXT_CLR))
        u_ext (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata), .q(ext_q));

    pind_setclr #(.W(NPINS), .ADDR_W(ADDR_W), .SET_OFS(OFS_LVL_SET), .CLR_OFS(OFS_LVL_CLR))
        u_lvl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata), .q(lvl_q));

    pind_setclr #(.W(NPINS), .ADDR_W(ADDR_W), .SET_OFS(OFS_POL_SET), .CLR_OFS(OFS_POL_CLR))
        u_pol (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata), .q(pol_q));

    pind_detect #(.NPINS(NPINS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .ext_en  (ext_q),
        .lvl_sel (lvl_q),
        .pol_sel (pol_q),
        .prev_o  (prev_q),
        .event_o (events)
    );

    pind_status #(.NPINS(NPINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (events),
        .clr_i    (rd_clr),
        .mask_i   (mask_q),
        .status_o (status_q),
        .irq_o    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (op == BUS_READ) begin
            case (bus_addr)
                ADDR_W'(OFS_MASK_RD): bus_rdata = mask_q;
                ADDR_W'(OFS_STAT_RD): bus_rdata = status_q;
                ADDR_W'(OFS_EXT_RD):  bus_rdata = ext_q;
                ADDR_W'(OFS_LVL_RD):  bus_rdata = lvl_q;
                ADDR_W'(OFS_POL_RD):  bus_rdata = pol_q;
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pind_checker.sv
module pind_checker #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] prev_q,
    input logic [NPINS-1:0] ext_q,
    input logic [NPINS-1:0] lvl_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] status_q,
    input logic             rd_clr,
    input logic             irq
);

    logic [NPINS-1:0] any_edge_hit;
    logic [NPINS-1:0] lvl_hit;
    logic [NPINS-1:0] dir_mode;
    logic [NPINS-1:0] dir_ok;
    logic [NPINS-1:0] all_hit;

    assign any_edge_hit = (pin_in ^ prev_q) & ~ext_q;
    assign lvl_hit      = ext_q & lvl_q & ~(pin_in ^ pol_q);
    assign dir_mode     = ext_q & ~lvl_q;
    assign dir_ok       = (pol_q & pin_in & ~prev_q) | (~pol_q & ~pin_in & prev_q);
    assign all_hit      = any_edge_hit | lvl_hit | (dir_mode & dir_ok);

    // R6: any change on a pin outside extended mode is latched
    a_r6_any_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(any_edge_hit)) == $past(any_edge_hit)));

    // R7: a directional edge pin only gains status on the selected edge
    a_r7_no_wrong_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(dir_mode) & ~$past(dir_ok)) == '0));

    // R8: level condition re-latches every clock
    a_r8_level_relatch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(lvl_hit)) == $past(lvl_hit)));

    // R9: a clearing read leaves only bits from events seen at that edge
    a_r9_clear_drops_stale: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((status_q & ~$past(all_hit)) == '0));

    // R10: no request without collected events or without mask bits
    a_r10_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq);

    a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

bind pin_irq_detector pind_checker #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .prev_q   (prev_q),
    .ext_q    (ext_q),
    .lvl_q    (lvl_q),
    .pol_q    (pol_q),
    .mask_q   (mask_q),
    .status_q (status_q),
    .rd_clr   (rd_clr),
    .irq      (irq)
);

// File: tb/pin_irq_detector_tb.sv
module pin_irq_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_mask, m_ext, m_lvl, m_pol, m_stat, m_prev, cur_pins;

    always #4 clk = ~clk;

    pin_irq_detector u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_events(input logic [31:0] p);
        logic [31:0] e = '0;
        for (int i = 0; i < 32; i++) begin
            if (!m_ext[i])      e[i] = p[i] ^ m_prev[i];
            else if (m_lvl[i])  e[i] = (p[i] == m_pol[i]);
            else if (m_pol[i])  e[i] = p[i] & ~m_prev[i];
            else                e[i] = ~p[i] & m_prev[i];
        end
        return e;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h48: return m_mask;
            8'h4C: return m_stat;
            8'hB8: return m_ext;
            8'hC8: return m_lvl;
            8'hD8: return m_pol;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h48: return "R2";
            8'h4C: return "R9";
            8'hB8: return "R3";
            8'hC8: return "R4";
            8'hD8: return "R5";
            default: return "R1";
        endcase
    endfunction

    // one bus cycle; compares irq and read data with the model, then advances the model
    task automatic step(input logic en, input logic wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic [31:0] pins,
                        output logic [31:0] rd);
        logic [31:0] ev;
        @(negedge clk);
        bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_in = pins;
        #1;
        rd = bus_rdata;
        check("R10", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
        if (en && !wr) check(tag_of(a), rd, model_read(a));
        @(posedge clk);
        ev = model_events(pins);
        if (en && wr) begin
            case (a)
                8'h40: m_mask |= wd;
                8'h44: m_mask &= ~wd;
                8'hB0: m_ext  |= wd;
                8'hB4: m_ext  &= ~wd;
                8'hC4: m_lvl  |= wd;
                8'hC0: m_lvl  &= ~wd;
                8'hD4: m_pol  |= wd;
                8'hD0: m_pol  &= ~wd;
                default: ;
            endcase
        end
        m_stat = ((en && !wr && a == 8'h4C) ? 32'd0 : m_stat) | ev;
        m_prev = pins;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r;
        step(1'b1, 1'b1, a, d, cur_pins, r);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        step(1'b1, 1'b0, a, '0, cur_pins, r);
    endtask

    task automatic idle();
        logic [31:0] r;
        step(1'b0, 1'b0, '0, '0, cur_pins, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_mask = '0; m_ext = '0; m_lvl = '0; m_pol = '0; m_stat = '0; m_prev = '0;
        cur_pins = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h48, r); check("R1", r, 0);
        rd(8'hB8, r); check("R1", r, 0);
        rd(8'hC8, r); check("R1", r, 0);
        rd(8'hD8, r); check("R1", r, 0);
        rd(8'h4C, r); check("R1", r, 0);
        rd(8'h50, r); check("R1", r, 0);
        check("R1", {31'd0, irq}, 32'd0);

        // R2: set/clear touches only written bits
        wr(8'h40, 32'h0000_00F0);
        wr(8'h44, 32'h0000_0030);
        rd(8'h48, r); check("R2", r, 32'h0000_00C0);
        wr(8'h44, 32'h0000_00C0);

        // R6, R11: both edges latch outside extended mode, even with lvl/pol bits set
        wr(8'hC4, 32'h1); wr(8'hD4, 32'h1);
        cur_pins = 32'h1; idle();
        rd(8'h4C, r); check("R6", r & 32'h1, 32'h1);
        rd(8'h4C, r); check("R9", r, 32'h0);
        cur_pins = 32'h0; idle();
        rd(8'h4C, r); check("R11", r & 32'h1, 32'h1);
        wr(8'hC0, 32'h1); wr(8'hD0, 32'h1);

        // R3, R5, R7: pin1 rising only
        wr(8'hB0, 32'h2); wr(8'hD4, 32'h2);
        rd(8'hB8, r); check("R3", r, 32'h2);
        rd(8'hD8, r); check("R5", r, 32'h2);
        rd(8'h4C, r);
        cur_pins = 32'h2; idle();
        rd(8'h4C, r); check("R7", r & 32'h2, 32'h2);
        cur_pins = 32'h0; idle();
        rd(8'h4C, r); check("R7", r & 32'h2, 32'h0);

        // R4, R8: pin2 low level re-latches through a clearing read
        wr(8'hB0, 32'h4); wr(8'hC4, 32'h4);
        rd(8'hC8, r); check("R4", r, 32'h4);
        rd(8'h4C, r); check("R8", r & 32'h4, 32'h4);
        rd(8'h4C, r); check("R8", r & 32'h4, 32'h4);
        cur_pins = 32'h4; idle();
        rd(8'h4C, r);
        rd(8'h4C, r); check("R8", r & 32'h4, 32'h0);
        wr(8'hC0, 32'h4);
        rd(8'hC8, r); check("R4", r, 32'h0);

        // R10: masked pin latches without irq; unmasking raises irq
        rd(8'h4C, r);
        cur_pins = 32'h5; idle();
        @(negedge clk); #1;
        check("R10", {31'd0, irq}, 32'd0);
        wr(8'h40, 32'h1);
        @(negedge clk); #1;
        check("R10", {31'd0, irq}, 32'd1);
        rd(8'h4C, r); check("R10", r & 32'h1, 32'h1);
        @(negedge clk); #1;
        check("R10", {31'd0, irq}, 32'd0);

        // R3: leaving extended mode restores both-edge detection
        wr(8'hB4, 32'h2);
        rd(8'h4C, r);
        cur_pins = 32'h7; idle();
        cur_pins = 32'h5; idle();
        rd(8'h4C, r); check("R6", r & 32'h2, 32'h2);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  addrs [14] = '{8'h40, 8'h44, 8'h48, 8'h4C, 8'hB0, 8'hB4, 8'hB8,
                                        8'hC0, 8'hC4, 8'hC8, 8'hD0, 8'hD4, 8'hD8, 8'h60};
            logic [7:0]  a  = addrs[$urandom_range(0, 13)];
            logic        en = ($urandom_range(0, 3) != 0);
            logic        w  = (a != 8'h48 && a != 8'h4C && a != 8'hB8 &&
                               a != 8'hC8 && a != 8'hD8) ? ($urandom_range(0, 4) != 0) : 1'b0;
            logic [31:0] d  = $urandom() & $urandom();
            if ($urandom_range(0, 2) == 0) cur_pins ^= ($urandom() & $urandom() & $urandom());
            step(en, w, a, d, cur_pins, r);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule